// File: doc/BRIEF.md
# Byte-Stream Pixel Assembler

This block takes a parallel video stream that may be narrower than a pixel and rebuilds whole pixels for a TFT panel bus. In the wide mode a 16-bit RGB565 word enters every valid cycle and leaves the same cycle. In the two byte modes the low eight data lines carry one byte per valid cycle. Two bytes build an RGB565 pixel and three bytes build an RGB888 pixel. A single strobe marks each finished pixel.

Each mode has a fixed pipeline depth. The line and frame syncs are delayed by exactly that depth, so they leave aligned with the pixels. Upstream timing must shift its first-pixel position by the same amount. A channel-order input swaps the red and blue fields. The finished pixel is presented in two forms: as a packed word, and as an 18-bit panel triple. In the 18-bit triple, RGB565 red and blue are widened by copying their top bit into a new bottom bit. RGB888 channels are cut to their upper six bits.

Top module: `pixel_assembler`

## Requirements
- R1: With `mode` = 0, every cycle with `in_valid` high and `in_hsync` low raises `pix_stb` in that same cycle. `in_data[15:0]` is taken as one RGB565 word, so the added latency is zero.
- R2: With `mode` = 1, two bytes on `in_data[7:0]` form one RGB565 word, high byte first. `pix_stb` rises 2 cycles after the cycle of the second byte. With back-to-back bytes, this is 3 cycles after the first byte. Idle cycles between the bytes hold the partial pixel.
- R3: With `mode` = 2, three bytes form one 24-bit word, most significant byte first. `pix_stb` rises 3 cycles after the third byte, which is 5 cycles after the first byte when the bytes are contiguous.
- R4: In the RGB565 modes, `pix_word[15:0]` holds the word and `pix_word[23:16]` is 0. With `bgr` = 0, red is bits 15:11, green is bits 10:5 and blue is bits 4:0. With `bgr` = 1, red is bits 4:0 and blue is bits 15:11. Green keeps bits 10:5 in both orders.
- R5: In `mode` = 2, `pix_word` holds the 24-bit word. With `bgr` = 0, red is bits 23:16, green is bits 15:8 and blue is bits 7:0. With `bgr` = 1, red is bits 7:0 and blue is bits 23:16.
- R6: The 6-bit panel channels are formed as follows. For RGB565, `pan_r` and `pan_b` are the 5-bit field followed by a copy of that field's top bit, and `pan_g` is the 6-bit field. For RGB888, each of the three channels is the upper six bits of its 8-bit field.
- R7: A cycle with `in_hsync` high clears the byte position. A partial pixel is dropped and produces no strobe. A byte marked valid in that same cycle is discarded. The next line therefore starts on a pixel boundary.
- R8: `out_hsync` and `out_vsync` repeat `in_hsync` and `in_vsync` after 0, 3 or 5 cycles for modes 0, 1 and 2.
- R9: `mode` = 3 behaves exactly like `mode` = 0. In the byte modes, `in_data[15:8]` has no effect on any output.
- R10: During reset and after it is released, `pix_stb`, `out_hsync` and `out_vsync` are low until input activity reaches them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/3 wide RGB565, 1 RGB565 over bytes, 2 RGB888 over bytes |
| bgr | input | 1 | 1 swaps red and blue field positions |
| in_data | input | 16 | Wide word, or a byte on bits 7:0 |
| in_valid | input | 1 | Data on `in_data` is valid this cycle |
| in_hsync | input | 1 | Line sync, active high |
| in_vsync | input | 1 | Frame sync, active high |
| pix_word | output | 24 | Assembled packed pixel word |
| pan_r | output | 6 | Panel red channel |
| pan_g | output | 6 | Panel green channel |
| pan_b | output | 6 | Panel blue channel |
| pix_stb | output | 1 | Pixel outputs valid this cycle |
| out_hsync | output | 1 | Line sync, delayed by the mode latency |
| out_vsync | output | 1 | Frame sync, delayed by the mode latency |

## Verification
Some properties are checked on every cycle once the mode has held steady for a few cycles. These are the sync delays in both byte modes, the wide-mode pass-through, the minimum spacing between pixel strobes in the byte modes, and the top-bit copy in the RGB565 panel channels. Other behaviour can only be shown by the bench's scenarios: the byte order inside a pixel, the field placement in both channel orders, the exact strobe cycle after gaps, and the realignment after a truncated line or a byte that collides with sync. The bench shows these by sweeping walking-one and all-ones pixels through every mode and order, and comparing each strobe against values it computes itself.

// File: rtl/pixel_assembler.sv
module pixel_assembler (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        bgr,
  input  logic [15:0] in_data,
  input  logic        in_valid,
  input  logic        in_hsync,
  input  logic        in_vsync,
  output logic [23:0] pix_word,
  output logic [5:0]  pan_r,
  output logic [5:0]  pan_g,
  output logic [5:0]  pan_b,
  output logic        pix_stb,
  output logic        out_hsync,
  output logic        out_vsync
);

  localparam int PIX_W = 25;

  logic m565, m888, mwide;
  assign m565  = (mode == 2'd1);
  assign m888  = (mode == 2'd2);
  assign mwide = !m565 && !m888;

  logic [1:0] cnt;
  logic [7:0] h0, h1;
  logic       byte_ok, last;

  assign byte_ok = in_valid && !in_hsync;
  assign last    = m565 ? (cnt != 2'd0) : (cnt >= 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 2'd0;
      h0  <= 8'd0;
      h1  <= 8'd0;
    end else if (in_hsync || mwide) begin
      cnt <= 2'd0;
    end else if (in_valid) begin
      cnt <= last ? 2'd0 : cnt + 2'd1;
      if (cnt == 2'd0) h0 <= in_data[7:0];
      if (cnt == 2'd1) h1 <= in_data[7:0];
    end
  end

  logic              asm_stb;
  logic [23:0]       asm_word;

  assign asm_stb  = mwide ? byte_ok : (byte_ok && last);
  assign asm_word = mwide ? {8'h00, in_data}
                  : m565  ? {8'h00, h0, in_data[7:0]}
                  :         {h0, h1, in_data[7:0]};

  logic [2:0][PIX_W-1:0] pd;
  logic [4:0][1:0]       sd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd <= '0;
      sd <= '0;
    end else begin
      pd <= {pd[1:0], {asm_stb, asm_word}};
      sd <= {sd[3:0], {in_hsync, in_vsync}};
    end
  end

  logic [PIX_W-1:0] sel_p;
  logic [1:0]       sel_s;

  assign sel_p = m565 ? pd[1] : m888 ? pd[2] : {asm_stb, asm_word};
  assign sel_s = m565 ? sd[2] : m888 ? sd[4] : {in_hsync, in_vsync};

  assign pix_stb   = sel_p[24];
  assign pix_word  = sel_p[23:0];
  assign out_hsync = sel_s[1];
  assign out_vsync = sel_s[0];

  always_comb begin
    if (m888) begin
      pan_r = bgr ? pix_word[7:2]   : pix_word[23:18];
      pan_g = pix_word[15:10];
      pan_b = bgr ? pix_word[23:18] : pix_word[7:2];
    end else begin
      pan_r = bgr ? {pix_word[4:0], pix_word[4]}     : {pix_word[15:11], pix_word[15]};
      pan_g = pix_word[10:5];
      pan_b = bgr ? {pix_word[15:11], pix_word[15]}  : {pix_word[4:0], pix_word[4]};
    end
  end

  logic [1:0] mode_q;
  logic [2:0] mode_age;
  logic       settled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'd0;
      mode_age <= 3'd0;
    end else begin
      mode_q <= mode;
      if (mode != mode_q)       mode_age <= 3'd0;
      else if (mode_age != 3'd7) mode_age <= mode_age + 3'd1;
    end
  end

  assign settled = (mode_age >= 3'd6) && (mode == mode_q);

  assert_sync_delay_565_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && m565) |-> ({out_hsync, out_vsync} == $past({in_hsync, in_vsync}, 3)));

  assert_sync_delay_888_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && m888) |-> ({out_hsync, out_vsync} == $past({in_hsync, in_vsync}, 5)));

  assert_wide_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mwide |-> ((pix_stb == (in_valid && !in_hsync)) && (pix_word[15:0] == in_data)));

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !mwide && pix_stb) |=> (!pix_stb || (mode != $past(mode))));

  assert_msb_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!m888) |-> ((pan_r[0] == pan_r[5]) && (pan_b[0] == pan_b[5])));

endmodule

// File: tb/pixel_assembler_tb_top.sv
module pixel_assembler_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bgr = 1'b0;
  logic [15:0] in_data = 16'h0;
  logic        in_valid = 1'b0;
  logic        in_hsync = 1'b0;
  logic        in_vsync = 1'b0;
  logic [23:0] pix_word;
  logic [5:0]  pan_r, pan_g, pan_b;
  logic        pix_stb, out_hsync, out_vsync;

  always #2 clk = ~clk;

  pixel_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bgr(bgr), .in_data(in_data),
    .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .pix_word(pix_word), .pan_r(pan_r), .pan_g(pan_g), .pan_b(pan_b),
    .pix_stb(pix_stb), .out_hsync(out_hsync), .out_vsync(out_vsync));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int          exp_cyc_q[$];
  logic [41:0] exp_val_q[$];
  string       exp_tag_q[$];
  int          hs_q[$];
  int          vs_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat_of(input logic [1:0] m);
    return (m == 2'd1) ? 3 : (m == 2'd2) ? 5 : 0;
  endfunction

  function automatic logic [41:0] exp_of(input logic [1:0] m, input logic b, input int val);
    int w, hi, mid, lo, r, g, bl, t5, b5;
    if (m == 2'd2) begin
      w = val & 32'hFFFFFF;
      hi = (w >> 16) & 255; mid = (w >> 8) & 255; lo = w & 255;
      r = b ? lo : hi; bl = b ? hi : lo; g = mid;
      return {w[23:0], 6'(r / 4), 6'(g / 4), 6'(bl / 4)};
    end else begin
      w = val & 32'hFFFF;
      t5 = (w >> 11) & 31; g = (w >> 5) & 63; b5 = w & 31;
      r = b ? b5 : t5; bl = b ? t5 : b5;
      r = r * 2 + (r / 16); bl = bl * 2 + (bl / 16);
      return {8'h00, w[15:0], 6'(r), 6'(g), 6'(bl)};
    end
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    return (m == 2'd1) ? "R2/R4/R6" : (m == 2'd2) ? "R3/R5/R6" : (m == 2'd3) ? "R9/R1" : "R1/R4/R6";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pix_stb) begin
        checks++;
        if (exp_cyc_q.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected strobe cyc=%0d actual=%h expected=none", cyc, pix_word);
        end else begin
          int ec; logic [41:0] ev; string tg;
          ec = exp_cyc_q.pop_front(); ev = exp_val_q.pop_front(); tg = exp_tag_q.pop_front();
          if (cyc != ec || {pix_word, pan_r, pan_g, pan_b} != ev) begin
            failures++;
            $display("FAIL %s cyc actual=%0d expected=%0d value actual=%h expected=%h",
                     tg, cyc, ec, {pix_word, pan_r, pan_g, pan_b}, ev);
          end
        end
      end
      if (out_hsync) begin
        checks++;
        if (hs_q.size() == 0 || hs_q[0] != cyc) begin
          failures++;
          $display("FAIL R8 hsync actual=%0d expected=%0d", cyc, (hs_q.size() != 0) ? hs_q[0] : -1);
        end
        if (hs_q.size() != 0) void'(hs_q.pop_front());
      end
      if (out_vsync) begin
        checks++;
        if (vs_q.size() == 0 || vs_q[0] != cyc) begin
          failures++;
          $display("FAIL R8 vsync actual=%0d expected=%0d", cyc, (vs_q.size() != 0) ? vs_q[0] : -1);
        end
        if (vs_q.size() != 0) void'(vs_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog all-requirements actual=%0d expected<=50000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic [15:0] d, input logic hs, input logic vs);
    @(posedge clk); #1;
    in_valid = v; in_data = d; in_hsync = hs; in_vsync = vs;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic hpulse(input logic v, input logic [7:0] byt);
    drive(v, {8'hA5, byt}, 1'b1, 1'b0);
    hs_q.push_back(cyc + lat_of(mode));
  endtask

  task automatic vpulse();
    drive(1'b0, 16'h0, 1'b0, 1'b1);
    vs_q.push_back(cyc + lat_of(mode));
  endtask

  task automatic push_exp(input int c, input int val);
    exp_cyc_q.push_back(c);
    exp_val_q.push_back(exp_of(mode, bgr, val));
    exp_tag_q.push_back(tag_of(mode));
  endtask

  task automatic send_pix(input int val, input bit gap);
    logic [7:0] b2, b1, b0;
    b2 = 8'(val >> 16); b1 = 8'(val >> 8); b0 = 8'(val);
    if (mode == 2'd1) begin
      drive(1'b1, {~b1, b1}, 1'b0, 1'b0);
      if (gap) idle(1);
      drive(1'b1, {~b0, b0}, 1'b0, 1'b0);
      push_exp(cyc + 2, val);
    end else if (mode == 2'd2) begin
      drive(1'b1, {~b2, b2}, 1'b0, 1'b0);
      if (gap) idle(1);
      drive(1'b1, {b0, b1}, 1'b0, 1'b0);
      drive(1'b1, {b2, b0}, 1'b0, 1'b0);
      push_exp(cyc + 3, val);
    end else begin
      drive(1'b1, 16'(val), 1'b0, 1'b0);
      push_exp(cyc, val);
    end
  endtask

  task automatic drained(input string tg);
    checks++;
    if (exp_cyc_q.size() != 0 || hs_q.size() != 0 || vs_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing outputs actual=%0d expected=0", tg,
               exp_cyc_q.size() + hs_q.size() + vs_q.size());
      exp_cyc_q.delete(); exp_val_q.delete(); exp_tag_q.delete(); hs_q.delete(); vs_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pix_stb || out_hsync || out_vsync) begin
      failures++;
      $display("FAIL R10 in reset actual=%b expected=000", {pix_stb, out_hsync, out_vsync});
    end
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (pix_stb || out_hsync || out_vsync) begin
      failures++;
      $display("FAIL R10 after reset actual=%b expected=000", {pix_stb, out_hsync, out_vsync});
    end

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        idle(8);
        mode = 2'(m); bgr = 1'(b);
        idle(8);
        vpulse();
        idle(2);
        hpulse(1'b0, 8'h00);
        idle(1);
        for (int i = 0; i < ((m == 2) ? 24 : 16); i++) send_pix(1 << i, (i % 3) == 0);
        send_pix(32'hFFFFFF, 1'b0);
        send_pix(32'h5A3C96, 1'b1);
        send_pix(32'hA5C369, 1'b0);
        idle(8);
        drained(tag_of(2'(m)));
      end
    end

    for (int m = 1; m < 3; m++) begin
      idle(8);
      mode = 2'(m); bgr = 1'b0;
      idle(8);
      hpulse(1'b0, 8'h00);
      drive(1'b1, 16'h00E7, 1'b0, 1'b0);
      if (m == 2) drive(1'b1, 16'h0042, 1'b0, 1'b0);
      hpulse(1'b0, 8'h00);
      send_pix(32'h123456, 1'b0);
      send_pix(32'hFEDCBA, 1'b0);
      hpulse(1'b1, 8'h99);
      send_pix(32'h0F1E2D, 1'b0);
      send_pix(32'h8001FE, 1'b1);
      idle(8);
      drained("R7");
    end

    idle(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule